// File: doc/BRIEF.md
# Wake Event Trigger Generator

This block converts a one-cycle strobe, raised by an upstream frame recognizer when a valid wake frame has been seen, into a trigger that a host or power controller can act on. It runs in the 125 MHz receive clock domain and offers two behaviours chosen by a configuration write.

In pulse mode each strobe produces a high pulse of a programmable number of clock cycles: 8, 16, 32 or 64, which is about 64 ns, 128 ns, 256 ns or 512 ns at 125 MHz. In level mode a strobe sets a sticky flag that drives the trigger high. Only a configuration write carrying the clear bit brings it back down. A status output mirrors the sticky flag so that software can poll it before clearing it.

Top module: `wake_trig_gen`

## Requirements
- R1: With `detect_i` held low, `trig_o` stays low; a trigger is only ever started by a detect strobe.
- R2: In pulse mode (mode bit 0), a detect strobe sampled at clock edge k drives `trig_o` high after edge k for exactly 8 << `len` cycles. The 2-bit `len` field encodes 00 = 8, 01 = 16, 10 = 32 and 11 = 64 cycles.
- R3: A cycle with `cfg_wr_i` high stores `cfg_mode_i` (0 = pulse, 1 = level) and `cfg_len_i`. The stored values govern detect strobes in later cycles. A detect strobe in the same cycle as the write uses the previously stored values.
- R4: A detect strobe that arrives while a pulse is running restarts the count, so the pulse ends a full programmed width after the newest strobe.
- R5: In level mode, a detect strobe at edge k makes `trig_o` and `latch_sts_o` high after edge k.
- R6: Once set, the level flag stays high through further strobes, through mode or length writes, and through configuration writes whose clear bit is 0.
- R7: A configuration write with `cfg_clr_i` = 1 drops the level flag after that edge, provided no level-mode strobe occurs in the same cycle.
- R8: A mode or length write made while a pulse is running does not change the length of that pulse.
- R9: After reset, `trig_o` and `latch_sts_o` are low and no pulse is in progress.
- R10: If a clear write and a level-mode detect strobe occur in the same cycle, the strobe wins and the flag stays high.
- R11: `latch_sts_o` mirrors the sticky level flag only. A pulse-mode strobe never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| detect_i | input | 1 | One-cycle wake frame recognized strobe |
| cfg_wr_i | input | 1 | Configuration write enable |
| cfg_mode_i | input | 1 | Mode to store: 0 pulse, 1 level |
| cfg_len_i | input | 2 | Pulse length select to store |
| cfg_clr_i | input | 1 | Clear bit of the write; clears the level flag |
| trig_o | output | 1 | Wake trigger output, active high |
| latch_sts_o | output | 1 | Read-back of the sticky level flag |

## Verification
The bench builds the block with its default parameters: a base shift of 3 and a 2-bit length select. All four pulse widths, up to 64 cycles, can then be measured edge to edge within a few hundred cycles. A scoreboard compares each measured pulse width against the width predicted from the length code, the restart point and the time of any mid-pulse configuration write. Level-mode stickiness, clearing and the same-cycle clear-versus-strobe case are checked directly at the trigger and status ports.

// File: rtl/wake_trig_pkg.sv
package wake_trig_pkg;

   typedef enum logic {
      WK_PULSE = 1'b0,
      WK_LEVEL = 1'b1
   } wk_mode_e;

endpackage

// File: rtl/wake_cfg_reg.sv
module wake_cfg_reg
   import wake_trig_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             mode_i,
   input  logic [SEL_W-1:0] len_i,
   input  logic             clr_i,
   output wk_mode_e         mode_o,
   output logic [SEL_W-1:0] len_o,
   output logic             clr_req_o
);

   wk_mode_e         mode_q;
   logic [SEL_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= WK_PULSE;
         len_q  <= '0;
      end else if (wr_i) begin
         mode_q <= wk_mode_e'(mode_i);
         len_q  <= len_i;
      end
   end

   // clear acts in the cycle of the write itself
   assign clr_req_o = wr_i & clr_i;
   assign mode_o    = mode_q;
   assign len_o     = len_q;

endmodule

// File: rtl/wake_pulse_gen.sv
module wake_pulse_gen #(
   parameter int BASE_SHIFT = 3,
   parameter int SEL_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SEL_W-1:0] len_sel_i,
   output logic             active_o
);

   localparam int NUM_LEN = 1 << SEL_W;
   localparam int MAX_SH  = BASE_SHIFT + NUM_LEN - 1;
   localparam int CNT_W   = MAX_SH + 1;

   logic [CNT_W-1:0] len_tab [NUM_LEN];
   logic [CNT_W-1:0] cnt_q;

   for (genvar gi = 0; gi < NUM_LEN; gi++) begin : g_len
      assign len_tab[gi] = CNT_W'(1) << (BASE_SHIFT + gi);
   end

   // a start reloads the count, even mid-pulse
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= len_tab[len_sel_i];
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign active_o = (cnt_q != '0);

endmodule

// File: rtl/wake_level_latch.sv
module wake_level_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic q_r;

   // set has priority over clear
   always_ff @(posedge clk) begin
      if (!rst_n)     q_r <= 1'b0;
      else if (set_i) q_r <= 1'b1;
      else if (clr_i) q_r <= 1'b0;
   end

   assign q_o = q_r;

endmodule

// File: rtl/wake_trig_gen.sv
module wake_trig_gen
   import wake_trig_pkg::*;
#(
   parameter int BASE_SHIFT = 3,
   parameter int SEL_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             detect_i,
   input  logic             cfg_wr_i,
   input  logic             cfg_mode_i,
   input  logic [SEL_W-1:0] cfg_len_i,
   input  logic             cfg_clr_i,
   output logic             trig_o,
   output logic             latch_sts_o
);

   if (BASE_SHIFT < 1 || BASE_SHIFT > 16) begin : g_bad_base
      $error("wake_trig_gen: BASE_SHIFT out of range");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("wake_trig_gen: SEL_W out of range");
   end

   wk_mode_e         mode_q;
   logic [SEL_W-1:0] len_q;
   logic             clr_req;
   logic             pulse_act;
   logic             lvl_q;
   logic             start_pulse;
   logic             set_level;

   wake_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (cfg_wr_i),
      .mode_i    (cfg_mode_i),
      .len_i     (cfg_len_i),
      .clr_i     (cfg_clr_i),
      .mode_o    (mode_q),
      .len_o     (len_q),
      .clr_req_o (clr_req)
   );

   assign start_pulse = detect_i & (mode_q == WK_PULSE);
   assign set_level   = detect_i & (mode_q == WK_LEVEL);

   wake_pulse_gen #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_pulse),
      .len_sel_i (len_q),
      .active_o  (pulse_act)
   );

   wake_level_latch u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_level),
      .clr_i (clr_req),
      .q_o   (lvl_q)
   );

   assign trig_o      = pulse_act | lvl_q;
   assign latch_sts_o = lvl_q;

endmodule

// File: rtl/wake_trig_chk.sv
module wake_trig_chk
   import wake_trig_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     detect_i,
   input logic     cfg_wr_i,
   input logic     cfg_clr_i,
   input wk_mode_e mode_q,
   input logic     trig_o,
   input logic     latch_sts_o
);

   a_r2_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (detect_i && mode_q == WK_PULSE) |=> trig_o);

   a_r5_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (detect_i && mode_q == WK_LEVEL) |=> (trig_o && latch_sts_o));

   a_r6_level_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_sts_o && !(cfg_wr_i && cfg_clr_i)) |=> latch_sts_o);

   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && cfg_clr_i && !(detect_i && mode_q == WK_LEVEL)) |=> !latch_sts_o);

   a_r10_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && cfg_clr_i && detect_i && mode_q == WK_LEVEL) |=> latch_sts_o);

   a_r11_pulse_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_sts_o && mode_q == WK_PULSE) |=> !latch_sts_o);

   a_r11_status_drives_trig: assert property (@(posedge clk) disable iff (!rst_n)
      latch_sts_o |-> trig_o);

endmodule

bind wake_trig_gen wake_trig_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .detect_i    (detect_i),
   .cfg_wr_i    (cfg_wr_i),
   .cfg_clr_i   (cfg_clr_i),
   .mode_q      (mode_q),
   .trig_o      (trig_o),
   .latch_sts_o (latch_sts_o)
);

// File: tb/wake_trig_gen_test.sv
module wake_trig_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       detect_i = 1'b0;
   logic       cfg_wr_i = 1'b0;
   logic       cfg_mode_i = 1'b0;
   logic [1:0] cfg_len_i = 2'd0;
   logic       cfg_clr_i = 1'b0;
   logic       trig_o;
   logic       latch_sts_o;

   int n_run  = 0;
   int n_fail = 0;
   int run_len = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;
   int exp_q[$];

   always #10 clk = ~clk;

   wake_trig_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .detect_i    (detect_i),
      .cfg_wr_i    (cfg_wr_i),
      .cfg_mode_i  (cfg_mode_i),
      .cfg_len_i   (cfg_len_i),
      .cfg_clr_i   (cfg_clr_i),
      .trig_o      (trig_o),
      .latch_sts_o (latch_sts_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: measures each pulse width and compares with scoreboard
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (trig_o) run_len++;
         else if (run_len > 0) begin
            if (exp_q.size() == 0) check("R1 unexpected pulse", run_len, 0);
            else check("R2/R4/R8 pulse width", run_len, exp_q.pop_front());
            run_len = 0;
         end
      end
   end

   task automatic write_cfg(input bit mode, input bit [1:0] len, input bit clr);
      @(negedge clk);
      cfg_wr_i = 1'b1; cfg_mode_i = mode; cfg_len_i = len; cfg_clr_i = clr;
      @(negedge clk);
      cfg_wr_i = 1'b0; cfg_clr_i = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      detect_i = 1'b1;
      @(negedge clk);
      detect_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R9 reset state
      check("R9 trig after reset", int'(trig_o), 0);
      check("R9 status after reset", int'(latch_sts_o), 0);
      rst_n = 1'b1;
      idle(2);
      check("R9 trig idle", int'(trig_o), 0);

      // R1 no strobe, no trigger
      mon_en = 1'b1;
      idle(50);
      check("R1 trig without detect", int'(trig_o), 0);

      // R2/R3 all four widths
      for (int s = 0; s < 4; s++) begin
         write_cfg(1'b0, 2'(s), 1'b0);
         exp_q.push_back(8 << s);
         strobe();
         check("R11 status in pulse mode", int'(latch_sts_o), 0);
         idle(80);
      end

      // R4 restart: second strobe six edges after the first
      write_cfg(1'b0, 2'd0, 1'b0);
      exp_q.push_back(6 + 8);
      strobe();
      idle(4);
      strobe();
      idle(30);

      // R8 length change mid-pulse keeps 64
      write_cfg(1'b0, 2'd3, 1'b0);
      exp_q.push_back(64);
      strobe();
      idle(3);
      write_cfg(1'b0, 2'd0, 1'b0);
      write_cfg(1'b1, 2'd0, 1'b0);
      idle(80);
      check("R2 scoreboard drained", exp_q.size(), 0);
      mon_en = 1'b0;

      // level mode (mode stored 1 above)
      strobe();
      check("R5 trig after level detect", int'(trig_o), 1);
      check("R5 status after level detect", int'(latch_sts_o), 1);
      idle(100);
      check("R6 level held", int'(trig_o), 1);
      strobe();
      write_cfg(1'b1, 2'd2, 1'b0);
      check("R6 write without clear", int'(latch_sts_o), 1);
      write_cfg(1'b0, 2'd0, 1'b0);
      check("R6 mode change keeps flag", int'(trig_o), 1);
      write_cfg(1'b0, 2'd0, 1'b1);
      idle(1);
      check("R7 clear drops trig", int'(trig_o), 0);
      check("R7 clear drops status", int'(latch_sts_o), 0);

      // R10 clear and strobe together in level mode
      write_cfg(1'b1, 2'd0, 1'b0);
      strobe();
      @(negedge clk);
      detect_i = 1'b1; cfg_wr_i = 1'b1; cfg_clr_i = 1'b1; cfg_mode_i = 1'b1;
      @(negedge clk);
      detect_i = 1'b0; cfg_wr_i = 1'b0; cfg_clr_i = 1'b0;
      check("R10 detect beats clear", int'(latch_sts_o), 1);
      write_cfg(1'b1, 2'd0, 1'b1);
      check("R7 clear after tie", int'(latch_sts_o), 0);

      // R3 strobe in same cycle as write uses old (level) mode
      @(negedge clk);
      detect_i = 1'b1; cfg_wr_i = 1'b1; cfg_mode_i = 1'b0; cfg_len_i = 2'd0;
      @(negedge clk);
      detect_i = 1'b0; cfg_wr_i = 1'b0;
      check("R3 old mode applies", int'(latch_sts_o), 1);
      write_cfg(1'b0, 2'd0, 1'b1);
      idle(2);
      check("R11 cleared status", int'(latch_sts_o), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule